// File: doc/BRIEF.md
# Prioritized Address Window Chip-Select Decoder

This block sits beside an external bus cycle engine. When the engine starts a bus cycle, the block latches the bus address and compares it against four programmable address windows. Each window has a base, a size exponent, an enable bit and a configuration word. The block resolves overlapping hits with a fixed priority. It then drives one active-low chip-select line, and it hands the chosen configuration word and its index to the engine. An address that no enabled window covers falls to a default configuration, which has a chip-select line of its own.

The block also enforces an address-space limit. The limit decides how many upper address lines above bit 15 are driven. Lines that are not driven are held low, and they also read as zero in the window compare. The block generates the address-latch strobe for each cycle. Its chip-select edge can be placed either on the clock where the strobe rises, or one clock later. The clock is a half-period phase clock of the CPU, so one clock of delay equals half a CPU clock.

Top module: `addr_win_csdec`

## Requirements
- R1: A window matches when its enable bit is set and the effective address agrees with its base in every bit at or above its size exponent. An exponent of 0 matches a single byte. An exponent of 24 or more matches every address.
- R2: A window whose enable bit is clear never matches, whatever its base and exponent.
- R3: When windows overlap, the highest-numbered matching window is chosen. Window 4 beats window 3, window 3 beats window 2, and window 2 beats window 1. Window k is index k-1 in the `win_*` ports.
- R4: When no enabled window matches, `sel_o` is 0, `cs_n_o[0]` is the asserted line and `cfg_o` equals `dflt_cfg_i`. A match on window k gives `sel_o` = k, `cs_n_o[k]` low and `cfg_o` equal to that window's configuration word.
- R5: At most one bit of `cs_n_o` is low at any time. The clock edge that samples `end_i` (without `start_i`) drives all bits of `cs_n_o` high.
- R6: With `cs_early_i` = 1 at `start_i`, the chip-select changes on the same edge where `ale_o` rises. That edge is the one that samples `start_i`.
- R7: With `cs_early_i` = 0 at `start_i`, the chip-select change happens one clock after `ale_o` rises. Until then the previous value of `cs_n_o` is held.
- R8: `ale_o` rises on the edge that samples `start_i` and stays high for exactly two clocks, unless `end_i` ends it sooner.
- R9: `space_i` encodes the space limit: 00 = 64 KB (no upper lines), 01 = 256 KB (2 lines), 10 = 1 MB (4 lines), 11 = 16 MB (8 lines). `seg_oe_o` has the low N bits set. `seg_addr_o` carries address bits 16 and up, with the undriven bits forced to 0.
- R10: Windows are compared against the effective address, meaning the address with its undriven upper bits cleared. A base with bits set above the limit therefore cannot match.
- R11: After reset, `cs_n_o` is all ones and `ale_o`, `sel_o`, `cfg_o`, `seg_addr_o` and `seg_oe_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock (two per CPU clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock pulse starting a bus cycle; `addr_i` is valid with it |
| end_i | input | 1 | One-clock pulse ending the bus cycle |
| addr_i | input | ADDR_W | Bus address |
| win_en_i | input | NWIN | Enable bit per window |
| win_base_i | input | NWIN x ADDR_W | Base address per window |
| win_exp_i | input | NWIN x EXP_W | Size exponent per window (size = 2^exp bytes) |
| win_cfg_i | input | NWIN x CFG_W | Configuration word per window |
| dflt_cfg_i | input | CFG_W | Configuration word for uncovered addresses |
| space_i | input | 2 | Address-space limit code |
| cs_early_i | input | 1 | 1: chip-select changes with the strobe rise; 0: one clock later |
| ale_o | output | 1 | Address-latch strobe |
| cs_n_o | output | NWIN+1 | Active-low chip-selects; bit 0 default, bit k window k |
| sel_o | output | SEL_W | Selected set: 0 default, k window k |
| cfg_o | output | CFG_W | Selected configuration word |
| seg_addr_o | output | ADDR_W-16 | Upper address lines, undriven ones forced to 0 |
| seg_oe_o | output | ADDR_W-16 | Drive enable per upper address line |

## Verification
The bench targets address overlaps among all three kinds of pair: within the lower pair, within the upper pair, and across the two pairs. A priority resolver wired the wrong way would pick window 1 over window 2, or the lower pair over the upper pair. It also disables a window that would otherwise win, so that a design ignoring the enable bit shows the wrong `sel_o`. The bench covers the size-exponent extremes 0 and 24, where an off-by-one mask error would miss the exact byte or miss a far address. Each space limit is run with an address whose upper bits would otherwise select a window, which exposes any compare done on the raw address instead of the effective one. Both chip-select timings are run in turn, so a chip-select that moves one clock early or late shows up against the cycle-by-cycle model.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    // Address-space limit codes; the value decides how many upper lines drive.
    typedef enum logic [1:0] {
        SPACE_64K  = 2'b00,
        SPACE_256K = 2'b01,
        SPACE_1M   = 2'b10,
        SPACE_16M  = 2'b11
    } space_e;

    // Number of upper address lines driven for a limit code.
    function automatic int unsigned upper_lines(space_e s, int unsigned seg_w);
        case (s)
            SPACE_64K:  return 0;
            SPACE_256K: return 2;
            SPACE_1M:   return 4;
            default:    return seg_w;
        endcase
    endfunction

endpackage

// File: rtl/awin_match.sv
module awin_match #(
    parameter int ADDR_W = 24,
    parameter int EXP_W  = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic              en_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] keep;

    // Bits at or above the size exponent take part in the compare.
    always_comb begin
        for (int b = 0; b < ADDR_W; b++) begin
            keep[b] = (b >= int'(exp_i));
        end
    end

    assign hit_o = en_i && (((addr_i ^ base_i) & keep) == '0);

endmodule

// File: rtl/awin_prio.sv
module awin_prio #(
    parameter int NWIN  = 4,
    parameter int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [NWIN-1:0]  hit_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int NPAIR = NWIN / 2;

    logic [NPAIR-1:0]            pair_hit;
    logic [NPAIR-1:0][IDX_W-1:0] pair_idx;

    // Within a pair the upper window wins.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_hit[p] = hit_i[2*p] | hit_i[2*p+1];
        assign pair_idx[p] = hit_i[2*p+1] ? IDX_W'(2*p+1) : IDX_W'(2*p);
    end

    // Across pairs the higher pair wins: later iterations override.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int p = 0; p < NPAIR; p++) begin
            if (pair_hit[p]) begin
                any_o = 1'b1;
                idx_o = pair_idx[p];
            end
        end
    end

endmodule

// File: rtl/seg_limit.sv
module seg_limit
    import addr_win_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LOW_W  = 16,
    parameter int SEG_W  = ADDR_W - LOW_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        space_i,
    output logic [ADDR_W-1:0] eff_addr_o,
    output logic [SEG_W-1:0]  seg_addr_o,
    output logic [SEG_W-1:0]  seg_oe_o
);
    int unsigned lines;

    always_comb begin
        lines = upper_lines(space_e'(space_i), SEG_W);
        for (int i = 0; i < SEG_W; i++) begin
            seg_oe_o[i] = (i < int'(lines));
        end
        eff_addr_o = addr_i;
        for (int i = 0; i < SEG_W; i++) begin
            eff_addr_o[LOW_W+i] = addr_i[LOW_W+i] & seg_oe_o[i];
        end
        seg_addr_o = addr_i[ADDR_W-1:LOW_W] & seg_oe_o;
    end

endmodule

// File: rtl/addr_win_csdec.sv
module addr_win_csdec #(
    parameter int ADDR_W    = 24,
    parameter int NWIN      = 4,
    parameter int CFG_W     = 16,
    parameter int ALE_TICKS = 2,
    parameter int EXP_W     = $clog2(ADDR_W + 1),
    parameter int SEL_W     = $clog2(NWIN + 1),
    parameter int SEG_W     = ADDR_W - 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        end_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [NWIN-1:0]             win_en_i,
    input  logic [NWIN-1:0][ADDR_W-1:0] win_base_i,
    input  logic [NWIN-1:0][EXP_W-1:0]  win_exp_i,
    input  logic [NWIN-1:0][CFG_W-1:0]  win_cfg_i,
    input  logic [CFG_W-1:0]            dflt_cfg_i,
    input  logic [1:0]                  space_i,
    input  logic                        cs_early_i,
    output logic                        ale_o,
    output logic [NWIN:0]               cs_n_o,
    output logic [SEL_W-1:0]            sel_o,
    output logic [CFG_W-1:0]            cfg_o,
    output logic [SEG_W-1:0]            seg_addr_o,
    output logic [SEG_W-1:0]            seg_oe_o
);
    localparam int LOW_W  = ADDR_W - SEG_W;
    localparam int IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int ALE_CW = $clog2(ALE_TICKS) + 1;

    typedef struct packed {
        logic              ale;
        logic [ALE_CW-1:0] ale_cnt;
        logic              pend;
        logic [SEL_W-1:0]  sel;
        logic [NWIN:0]     cs_n;
        logic [CFG_W-1:0]  cfg;
        logic [SEG_W-1:0]  seg_addr;
        logic [SEG_W-1:0]  seg_oe;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] eff_addr;
    logic [SEG_W-1:0]  seg_addr_w, seg_oe_w;
    logic [NWIN-1:0]   hit;
    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;
    logic [SEL_W-1:0]  dec_sel;
    logic [CFG_W-1:0]  dec_cfg;

    seg_limit #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .SEG_W(SEG_W)) seg_i (
        .addr_i    (addr_i),
        .space_i   (space_i),
        .eff_addr_o(eff_addr),
        .seg_addr_o(seg_addr_w),
        .seg_oe_o  (seg_oe_w)
    );

    for (genvar k = 0; k < NWIN; k++) begin : g_win
        awin_match #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) match_i (
            .addr_i(eff_addr),
            .base_i(win_base_i[k]),
            .exp_i (win_exp_i[k]),
            .en_i  (win_en_i[k]),
            .hit_o (hit[k])
        );
    end

    awin_prio #(.NWIN(NWIN), .IDX_W(IDX_W)) prio_i (
        .hit_i(hit),
        .any_o(any_hit),
        .idx_o(win_idx)
    );

    always_comb begin
        dec_sel = any_hit ? (SEL_W'(win_idx) + SEL_W'(1)) : '0;
        dec_cfg = dflt_cfg_i;
        for (int k = 0; k < NWIN; k++) begin
            if (any_hit && (win_idx == IDX_W'(k))) begin
                dec_cfg = win_cfg_i[k];
            end
        end
    end

    function automatic logic [NWIN:0] sel_to_cs(logic [SEL_W-1:0] s);
        logic [NWIN:0] v;
        for (int k = 0; k <= NWIN; k++) begin
            v[k] = (s != SEL_W'(k));
        end
        return v;
    endfunction

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.ale      = 1'b1;
            st_d.ale_cnt  = ALE_CW'(ALE_TICKS - 1);
            st_d.sel      = dec_sel;
            st_d.cfg      = dec_cfg;
            st_d.seg_addr = seg_addr_w;
            st_d.seg_oe   = seg_oe_w;
            if (cs_early_i) begin
                st_d.cs_n = sel_to_cs(dec_sel);
                st_d.pend = 1'b0;
            end else begin
                st_d.pend = 1'b1;
            end
        end else begin
            if (st_q.ale_cnt != '0) begin
                st_d.ale_cnt = st_q.ale_cnt - ALE_CW'(1);
            end else begin
                st_d.ale = 1'b0;
            end
            if (st_q.pend) begin
                st_d.cs_n = sel_to_cs(st_q.sel);
                st_d.pend = 1'b0;
            end
            if (end_i) begin
                st_d.cs_n    = '1;
                st_d.pend    = 1'b0;
                st_d.ale     = 1'b0;
                st_d.ale_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ale_o      = st_q.ale;
    assign cs_n_o     = st_q.cs_n;
    assign sel_o      = st_q.sel;
    assign cfg_o      = st_q.cfg;
    assign seg_addr_o = st_q.seg_addr;
    assign seg_oe_o   = st_q.seg_oe;

endmodule

// File: rtl/addr_win_csdec_chk.sv
module addr_win_csdec_chk #(
    parameter int NWIN  = 4,
    parameter int SEG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             end_i,
    input logic             cs_early_i,
    input logic             ale_o,
    input logic [NWIN:0]    cs_n_o,
    input logic [SEG_W-1:0] seg_addr_o,
    input logic [SEG_W-1:0] seg_oe_o
);
    // R5
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R5
    end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !start_i) |=> (&cs_n_o));

    // R6
    early_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cs_early_i) |=> !(&cs_n_o));

    // R7
    late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !cs_early_i && (&cs_n_o)) |=> (&cs_n_o));

    // R7
    late_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !cs_early_i) ##1 (!start_i && !end_i) |=> !(&cs_n_o));

    // R8
    ale_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ale_o);

    // R9
    seg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_addr_o & ~seg_oe_o) == '0);

    // R9
    seg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(seg_oe_o) == 0) || ($countones(seg_oe_o) == 2) ||
        ($countones(seg_oe_o) == 4) || ($countones(seg_oe_o) == SEG_W));

endmodule

bind addr_win_csdec addr_win_csdec_chk #(.NWIN(NWIN), .SEG_W(SEG_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .end_i     (end_i),
    .cs_early_i(cs_early_i),
    .ale_o     (ale_o),
    .cs_n_o    (cs_n_o),
    .seg_addr_o(seg_addr_o),
    .seg_oe_o  (seg_oe_o)
);

// File: tb/addr_win_csdec_tb_top.sv
`timescale 1ns/1ps
module addr_win_csdec_tb_top;
    localparam int ADDR_W = 24;
    localparam int NWIN   = 4;
    localparam int CFG_W  = 16;
    localparam int EXP_W  = 5;
    localparam int SEL_W  = 3;
    localparam int SEG_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic end_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [NWIN-1:0] win_en_i = '0;
    logic [NWIN-1:0][ADDR_W-1:0] win_base_i = '0;
    logic [NWIN-1:0][EXP_W-1:0] win_exp_i = '0;
    logic [NWIN-1:0][CFG_W-1:0] win_cfg_i = '0;
    logic [CFG_W-1:0] dflt_cfg_i = 16'hD000;
    logic [1:0] space_i = 2'b11;
    logic cs_early_i = 1'b0;
    logic ale_o;
    logic [NWIN:0] cs_n_o;
    logic [SEL_W-1:0] sel_o;
    logic [CFG_W-1:0] cfg_o;
    logic [SEG_W-1:0] seg_addr_o, seg_oe_o;

    always #2.5 clk = ~clk;

    addr_win_csdec dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .end_i(end_i), .addr_i(addr_i),
        .win_en_i(win_en_i), .win_base_i(win_base_i), .win_exp_i(win_exp_i),
        .win_cfg_i(win_cfg_i), .dflt_cfg_i(dflt_cfg_i), .space_i(space_i),
        .cs_early_i(cs_early_i), .ale_o(ale_o), .cs_n_o(cs_n_o), .sel_o(sel_o),
        .cfg_o(cfg_o), .seg_addr_o(seg_addr_o), .seg_oe_o(seg_oe_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string tag = "R11";

    // Behavioural reference state
    int m_ale_rem = 0;
    bit m_pend = 1'b0;
    int m_sel = 0;
    int m_cs = 31;
    int m_cfg = 0;
    int m_seg = 0;
    int m_oe = 0;

    function automatic int lines_of(int code);
        if (code == 0) return 0;
        if (code == 1) return 2;
        if (code == 2) return 4;
        return 8;
    endfunction

    function automatic int decode(int a);
        int eff, w;
        eff = a & ((1 << (16 + lines_of(int'(space_i)))) - 1);
        for (w = NWIN; w >= 1; w--) begin
            if (win_en_i[w-1] &&
                (((eff ^ int'(win_base_i[w-1])) >> int'(win_exp_i[w-1])) == 0))
                return w;
        end
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ale_rem = 0; m_pend = 0; m_sel = 0; m_cs = 31;
            m_cfg = 0; m_seg = 0; m_oe = 0;
        end else if (start_i) begin
            m_sel = decode(int'(addr_i));
            m_cfg = (m_sel == 0) ? int'(dflt_cfg_i) : int'(win_cfg_i[m_sel-1]);
            m_oe = (1 << lines_of(int'(space_i))) - 1;
            m_seg = (int'(addr_i) >> 16) & m_oe;
            m_ale_rem = 2;
            if (cs_early_i) begin
                m_cs = 31 & ~(1 << m_sel);
                m_pend = 0;
            end else begin
                m_pend = 1;
            end
        end else begin
            if (m_ale_rem > 0) m_ale_rem--;
            if (m_pend) begin
                m_cs = 31 & ~(1 << m_sel);
                m_pend = 0;
            end
            if (end_i) begin
                m_cs = 31; m_pend = 0; m_ale_rem = 0;
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model, away from the active edge.
    task automatic tick();
        @(negedge clk);
        check("ale", int'(ale_o), (m_ale_rem > 0) ? 1 : 0);
        check("cs_n", int'(cs_n_o), m_cs);
        check("sel", int'(sel_o), m_sel);
        check("cfg", int'(cfg_o), m_cfg);
        check("seg_addr", int'(seg_addr_o), m_seg);
        check("seg_oe", int'(seg_oe_o), m_oe);
    endtask

    task automatic bus_cycle(string t, int a, bit early, int exp_sel);
        tag = t;
        cs_early_i = early;
        addr_i = ADDR_W'(a);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        tick();
        tick();
        check("directed sel", int'(sel_o), exp_sel);
        tick();
        end_i = 1'b1;
        tick();
        end_i = 1'b0;
        tick();
    endtask

    initial begin
        win_base_i[0] = 24'h010000; win_exp_i[0] = 5'd16; win_cfg_i[0] = 16'hA001;
        win_base_i[1] = 24'h018000; win_exp_i[1] = 5'd15; win_cfg_i[1] = 16'hA002;
        win_base_i[2] = 24'h100000; win_exp_i[2] = 5'd20; win_cfg_i[2] = 16'hA003;
        win_base_i[3] = 24'h140000; win_exp_i[3] = 5'd18; win_cfg_i[3] = 16'hA004;
        win_en_i = 4'b1111;
        repeat (3) @(negedge clk);
        // R11: reset values
        tag = "R11";
        check("reset cs_n", int'(cs_n_o), 31);
        check("reset ale", int'(ale_o), 0);
        check("reset sel", int'(sel_o), 0);
        check("reset seg_oe", int'(seg_oe_o), 0);
        rst_n = 1'b1;
        tick();

        bus_cycle("R1", 24'h012345, 1'b0, 1);
        bus_cycle("R3", 24'h019000, 1'b0, 2);
        bus_cycle("R3", 24'h150000, 1'b1, 4);
        bus_cycle("R1", 24'h120000, 1'b1, 3);
        bus_cycle("R4", 24'h300000, 1'b0, 0);
        bus_cycle("R6", 24'h01FFFF, 1'b1, 2);
        bus_cycle("R7", 24'h01FFFF, 1'b0, 2);
        bus_cycle("R8", 24'h000010, 1'b1, 0);

        // R2: a disabled window that would win loses to its partner
        win_en_i = 4'b1101;
        bus_cycle("R2", 24'h019000, 1'b0, 1);
        win_en_i = 4'b0111;
        bus_cycle("R2", 24'h150000, 1'b1, 3);
        win_en_i = 4'b1111;

        // R3: upper pair beats lower pair on a cross-pair overlap
        win_base_i[2] = 24'h000000;
        bus_cycle("R3", 24'h019100, 1'b0, 3);
        win_base_i[2] = 24'h100000;

        // R9 / R10: space limits
        space_i = 2'b10;
        bus_cycle("R10", 24'h150000, 1'b0, 0);
        space_i = 2'b00;
        bus_cycle("R9", 24'h012345, 1'b1, 0);
        space_i = 2'b01;
        bus_cycle("R9", 24'h012345, 1'b0, 1);
        space_i = 2'b11;
        bus_cycle("R9", 24'hFF1234, 1'b0, 0);

        // R1: exponent extremes
        win_base_i[0] = 24'h000000; win_exp_i[0] = 5'd24;
        bus_cycle("R1", 24'h300000, 1'b1, 1);
        win_base_i[0] = 24'h222222; win_exp_i[0] = 5'd0;
        bus_cycle("R1", 24'h222222, 1'b0, 1);
        bus_cycle("R1", 24'h222223, 1'b0, 0);

        // R5: all chip-selects idle after the last end
        tag = "R5";
        repeat (3) tick();
        check("idle cs_n", int'(cs_n_o), 31);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule